// File: doc/BRIEF.md
# Bit Test, Clear and Set Unit

This unit carries out the single-bit operations of a byte-wide processor datapath. It can test one bit of an operand, clear one bit, or force one bit to one. The decoder hands it the operand byte, the number of the bit to act on, a two-bit operation code, the current flag byte, the value of the core's internal 16-bit address/temp register, and a line that says whether the operand came from memory or from a register. One clock later the unit presents the result byte, the new flag byte and a write-enable for the destination.

A test writes nothing back. It rebuilds the flag byte from the selected bit. A clear or a set writes the changed byte back and leaves every flag as it was. Bits 5 and 3 of the flag byte are copies of internal state that software does not normally use. For a register operand they are copies of operand bits 5 and 3. For a memory operand, including the indexed form, they come from bits 13 and 11 of the internal temp register, which then holds the effective address. Fetch, bus timing and address generation all sit outside this unit.

Top module: `bitop_unit`

## Requirements
- R1: While `rst_n` is low, and until the first accepted request, `out_valid`, `result`, `flags_out` and `wr_en` are all 0.
- R2: Each request taken with `in_valid` high appears with `out_valid` high exactly one clock later. A cycle without `in_valid` gives `out_valid` low on the next clock.
- R3: `op_code` values: 2'b01 test, 2'b10 clear, 2'b11 set, 2'b00 no operation. `bit_idx` selects the operand bit numbered 0 (LSB) to 7.
- R4: For a test, `wr_en` is 0 and `result` equals the operand. In the flag byte, bit 4 (half carry) is 1, bit 1 (subtract) is 0 and bit 0 (carry) keeps its input value.
- R5: For a test, flag bit 6 (zero) and flag bit 2 (parity/overflow) are both 1 when the selected bit is 0, and both 0 otherwise.
- R6: For a test, flag bit 7 (sign) is 1 only when `bit_idx` is 7 and operand bit 7 is 1.
- R7: For a test with `mem_sel` = 0, flag bits 5 and 3 equal operand bits 5 and 3.
- R8: For a test with `mem_sel` = 1, flag bit 5 equals `tmp_val[13]` and flag bit 3 equals `tmp_val[11]`. Operand bits 5 and 3 have no effect on them.
- R9: A clear returns the operand with the selected bit forced to 0, sets `wr_en` to 1 and returns `flags_in` unchanged.
- R10: A set returns the operand with the selected bit forced to 1, sets `wr_en` to 1 and returns `flags_in` unchanged.
- R11: Code 2'b00 returns the operand unchanged, `flags_in` unchanged and `wr_en` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op_code | input | 2 | Operation: 01 test, 10 clear, 11 set, 00 none |
| bit_idx | input | 3 | Number of the selected bit |
| operand | input | 8 | Operand byte |
| flags_in | input | 8 | Current flag byte |
| tmp_val | input | 16 | Internal address/temp register value |
| mem_sel | input | 1 | 1 when the operand was read from memory |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 8 | Byte for write-back |
| flags_out | output | 8 | New flag byte |
| wr_en | output | 1 | Destination is to be written |

## Verification
The case that is hardest to reach is a memory-form test in which bits 13 and 11 of the temp register differ from operand bits 5 and 3. Only then can a swapped source for the two copied flag bits be seen. The stimulus derives the temp value from the complement of the operand, so every memory-form test in the full sweep sets up this disagreement. The sweep covers every operand byte, every bit number, every operation code and both operand forms. The flag byte varies with the operand, so the carry bit takes both values under test. Idle cycles are mixed in so that the valid timing is checked as well.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [1:0] {
        OPC_NONE = 2'b00,
        OPC_TEST = 2'b01,
        OPC_CLR  = 2'b10,
        OPC_SET  = 2'b11
    } opc_e;

    localparam int FLAG_W = 8;

    // flag byte positions read by the rest of the core
    localparam int FL_SIGN = 7;
    localparam int FL_ZERO = 6;
    localparam int FL_CPY5 = 5;
    localparam int FL_HALF = 4;
    localparam int FL_CPY3 = 3;
    localparam int FL_PV   = 2;
    localparam int FL_SUB  = 1;
    localparam int FL_CARRY = 0;

    // temp register bits copied in the memory form
    localparam int TMP_SRC5 = 13;
    localparam int TMP_SRC3 = 11;

endpackage

// File: rtl/bitop_mask.sv
module bitop_mask #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] mask
);

    for (genvar i = 0; i < DATA_W; i++) begin : g_dec
        assign mask[i] = (idx == IDX_W'(i));
    end

endmodule

// File: rtl/bitop_flags.sv
module bitop_flags
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [1:0]        op_code,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] mask,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic              src5_mem,
    input  logic              src3_mem,
    input  logic              mem_sel,
    output logic [FLAG_W-1:0] flags_new
);

    logic [DATA_W-1:0] picked;
    logic              hit;

    assign picked = operand & mask;
    assign hit    = |picked;

    always_comb begin
        flags_new = flags_in;
        if (opc_e'(op_code) == OPC_TEST) begin
            flags_new[FL_SIGN]  = picked[DATA_W-1];
            flags_new[FL_ZERO]  = !hit;
            flags_new[FL_PV]    = !hit;
            flags_new[FL_HALF]  = 1'b1;
            flags_new[FL_SUB]   = 1'b0;
            flags_new[FL_CPY5]  = mem_sel ? src5_mem : operand[5];
            flags_new[FL_CPY3]  = mem_sel ? src3_mem : operand[3];
        end
    end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_code,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [DATA_W-1:0] operand,
    input  logic [7:0]        flags_in,
    input  logic [ADDR_W-1:0] tmp_val,
    input  logic              mem_sel,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [7:0]        flags_out,
    output logic              wr_en
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic [FLAG_W-1:0] flg;
        logic              wr;
    } stage_t;

    stage_t            stage_d, stage_q;
    logic [DATA_W-1:0] mask;
    logic [FLAG_W-1:0] flags_new;
    logic              tmp_unused;

    assign tmp_unused = ^tmp_val;

    bitop_mask #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mask (
        .idx  (bit_idx),
        .mask (mask)
    );

    bitop_flags #(.DATA_W(DATA_W)) u_flags (
        .op_code   (op_code),
        .operand   (operand),
        .mask      (mask),
        .flags_in  (flags_in),
        .src5_mem  (tmp_val[TMP_SRC5]),
        .src3_mem  (tmp_val[TMP_SRC3]),
        .mem_sel   (mem_sel),
        .flags_new (flags_new)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        if (in_valid) begin
            stage_d.flg = flags_new;
            unique case (opc_e'(op_code))
                OPC_CLR: begin
                    stage_d.res = operand & ~mask;
                    stage_d.wr  = 1'b1;
                end
                OPC_SET: begin
                    stage_d.res = operand | mask;
                    stage_d.wr  = 1'b1;
                end
                default: begin
                    stage_d.res = operand;
                    stage_d.wr  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.vld;
    assign result    = stage_q.res;
    assign flags_out = stage_q.flg;
    assign wr_en     = stage_q.wr;

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [1:0] op_code,
    input logic [2:0] bit_idx,
    input logic [7:0] operand,
    input logic [7:0] flags_in,
    input logic       tmp5,
    input logic       tmp3,
    input logic       mem_sel,
    input logic       out_valid,
    input logic [7:0] result,
    input logic [7:0] flags_out,
    input logic       wr_en
);

    logic is_test;
    assign is_test = in_valid && (op_code == 2'b01);

    p_valid_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_test_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_test |=> (!wr_en && flags_out[4] && !flags_out[1]
                     && flags_out[0] == $past(flags_in[0])
                     && result == $past(operand)));

    p_zero_pv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_test |=> (flags_out[6] == flags_out[2]));

    p_sign_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_test && bit_idx != 3'd7) |=> !flags_out[7]);

    p_reg_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_test && !mem_sel) |=> (flags_out[5] == $past(operand[5])
                                   && flags_out[3] == $past(operand[3])));

    p_mem_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_test && mem_sel) |=> (flags_out[5] == $past(tmp5)
                                  && flags_out[3] == $past(tmp3)));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 2'b10) |=> (wr_en && flags_out == $past(flags_in)
            && $countones(result ^ $past(operand)) <= 1
            && (result & ~$past(operand)) == 8'h00));

    p_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 2'b11) |=> (wr_en && flags_out == $past(flags_in)
            && $countones(result ^ $past(operand)) <= 1
            && (~result & $past(operand)) == 8'h00));

    p_none_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 2'b00) |=> (!wr_en && result == $past(operand)
            && flags_out == $past(flags_in)));

endmodule

bind bitop_unit bitop_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_code   (op_code),
    .bit_idx   (bit_idx),
    .operand   (operand),
    .flags_in  (flags_in),
    .tmp5      (tmp_val[13]),
    .tmp3      (tmp_val[11]),
    .mem_sel   (mem_sel),
    .out_valid (out_valid),
    .result    (result),
    .flags_out (flags_out),
    .wr_en     (wr_en)
);

// File: tb/bitop_unit_tb.sv
module bitop_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    typedef struct {
        logic [7:0] res;
        logic [7:0] flg;
        logic       wr;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_code = 2'b00;
    logic [2:0]  bit_idx = 3'd0;
    logic [7:0]  operand = 8'h00;
    logic [7:0]  flags_in = 8'h00;
    logic [15:0] tmp_val = 16'h0000;
    logic        mem_sel = 1'b0;
    logic        out_valid;
    logic [7:0]  result;
    logic [7:0]  flags_out;
    logic        wr_en;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   running  = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bitop_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .bit_idx(bit_idx), .operand(operand), .flags_in(flags_in),
        .tmp_val(tmp_val), .mem_sel(mem_sel), .out_valid(out_valid),
        .result(result), .flags_out(flags_out), .wr_en(wr_en)
    );

    function automatic exp_t model(input logic [1:0] opc, input logic [2:0] idx,
                                   input logic [7:0] op, input logic [7:0] fl,
                                   input logic [15:0] tmp, input logic mem);
        exp_t e;
        logic b;
        b     = op[idx];
        e.res = op;
        e.flg = fl;
        e.wr  = 1'b0;
        case (opc)
            2'b01: begin
                e.flg = {(idx == 3'd7) && b, !b, mem ? tmp[13] : op[5], 1'b1,
                         mem ? tmp[11] : op[3], !b, 1'b0, fl[0]};
                e.tag = mem ? "R3 R4 R5 R6 R8" : "R3 R4 R5 R6 R7";
            end
            2'b10: begin e.res[idx] = 1'b0; e.wr = 1'b1; e.tag = "R3 R9"; end
            2'b11: begin e.res[idx] = 1'b1; e.wr = 1'b1; e.tag = "R3 R10"; end
            default: e.tag = "R3 R11";
        endcase
        return e;
    endfunction

    task automatic drive(input logic [1:0] opc, input logic [2:0] idx,
                         input logic [7:0] op, input logic [7:0] fl,
                         input logic [15:0] tmp, input logic mem);
        @(negedge clk);
        sb_q.push_back(model(opc, idx, op, fl, tmp, mem));
        in_valid = 1'b1;
        op_code  = opc;
        bit_idx  = idx;
        operand  = op;
        flags_in = fl;
        tmp_val  = tmp;
        mem_sel  = mem;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        operand  = ~operand;
    endtask

    // monitor: outputs settle after posedge, compared at negedge
    always @(negedge clk) begin
        if (running && out_valid) begin
            if (sb_q.size() == 0) begin
                n_checks++;
                n_fails++;
                $display("FAIL R2: out_valid=1 expected 0 (no request pending)");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (result !== e.res || flags_out !== e.flg || wr_en !== e.wr) begin
                    n_fails++;
                    $display("FAIL %s: res=%02h flg=%02h wr=%0b expected res=%02h flg=%02h wr=%0b",
                             e.tag, result, flags_out, wr_en, e.res, e.flg, e.wr);
                end
            end
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_checks++;
        if ({out_valid, result, flags_out, wr_en} !== 18'd0) begin
            n_fails++;
            $display("FAIL R1: outputs=%05h expected 00000", {out_valid, result, flags_out, wr_en});
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R1: out_valid=%0b expected 0 after reset", out_valid);
        end
        running = 1'b1;

        for (int m = 0; m < 2; m++) begin
            for (int g = 0; g < 4; g++) begin
                for (int i = 0; i < 8; i++) begin
                    for (int v = 0; v < 256; v++) begin
                        logic [7:0]  op;
                        logic [7:0]  fl;
                        logic [15:0] tmp;
                        op  = 8'(v);
                        fl  = op ^ {8{v[0] ^ i[0]}} ^ 8'h3C;
                        tmp = {~op, op ^ 8'h5A};
                        drive(2'(g), 3'(i), op, fl, tmp, m[0]);
                        if (v % 61 == 0) idle();
                    end
                end
            end
        end
        idle();
        idle();
        // R2: idle cycle gives no result
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R2: out_valid=%0b expected 0 when idle", out_valid);
        end
        n_checks++;
        if (sb_q.size() != 0) begin
            n_fails++;
            $display("FAIL R2: %0d results missing, expected 0", sb_q.size());
        end
        finish_run();
    end

endmodule